// File: doc/BRIEF.md
# SMRAM Protected-Segment Address Decoder

This block sits on the CPU side of a memory controller. It classifies every memory access against two protected areas. The first is a segment carved downward from a fixed top of low memory. The second is a 128 KB high window that is relocated into low DRAM. For each access it picks a destination: DRAM (with the address to use there), the ordinary system path, or a blackhole responder. The blackhole returns all ones on reads and drops writes. Accesses of an unsupported size are rejected.

A small control register sets the segment. It holds an enable bit, a two-bit size code and a lock bit. Once the lock bit is set, the register stays frozen until reset. Code running in system-management mode sees the segment as plain DRAM. Any other master sees the blackhole there, in place of the RAM underneath. If a size code asks for more memory than exists below the top of low memory, the block raises a configuration error and disables the segment. Each access produces one registered response, one cycle later.

Top module: `smram_seg_decoder`

## Requirements
- R1: While reset is held and after it, `rsp_valid`, `ctl_rdata` and `cfg_err` read 0, so the segment is off.
- R2: With the enable bit (bit 0 of the control word) clear, no address hits the segment. Every valid access below the top of low memory goes to DRAM (route 1) at its own address.
- R3: The size code in control bits 2:1 decodes as 00 = 1 MB, 01 = 2 MB and 10 = 8 MB. Code 11 gives a size of zero, which disables the segment.
- R4: The segment covers [TOLM − size, TOLM). A non-SMM access there goes to the blackhole (route 2) at its own address, even though RAM lies underneath. `rsp_write` is 0. On a read, `rsp_rdata` has all ones in its lowest `acc_size` bytes and zeros above them.
- R5: An SMM access inside the segment goes to DRAM (route 1). `rsp_addr` equals `acc_addr` and `rsp_write` follows `acc_write`.
- R6: A valid access outside both protected areas goes to DRAM (route 1) at its own address when below TOLM. At or above TOLM it goes to the system path (route 0) with its address unchanged.
- R7: Access sizes of 1 to 4 bytes are accepted. Any other `acc_size` gives route 3 (reject), `rsp_write` 0 and `rsp_rdata` 0.
- R8: An SMM access in [0xFEDA0000, 0xFEDC0000) goes to DRAM at `acc_addr − 0xFEDA0000 + 0xA0000`. A non-SMM access there takes the system path unchanged.
- R9: A control write loads the enable bit (bit 0), the size code (bits 2:1) and the lock bit (bit 3). Once the lock bit is 1, later writes are ignored until reset, and `ctl_rdata` shows the held value.
- R10: A control change applies to accesses presented from the cycle after the write. An access presented in the same cycle as the write is decoded with the previous setting.
- R11: `cfg_err` is 1, one cycle after the control register changes, whenever the decoded size exceeds TOLM. In that case the segment is treated as size zero.
- R12: Each response appears one cycle after its access. `rsp_valid` is 1 exactly when `acc_valid` was 1 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control word: bit 0 enable, 2:1 size code, 3 lock |
| ctl_rdata | output | 4 | Current control register contents |
| cfg_err | output | 1 | Decoded segment size exceeds top of low memory |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_size | input | SIZE_W | Access size in bytes |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_smm | input | 1 | Access issued in system-management mode |
| rsp_valid | output | 1 | Response valid |
| rsp_route | output | 2 | 0 system, 1 DRAM, 2 blackhole, 3 reject |
| rsp_addr | output | ADDR_W | Address for the chosen destination |
| rsp_rdata | output | DATA_W | Blackhole read data (zero otherwise) |
| rsp_write | output | 1 | Write forwarded to the destination |

## Verification
Two functions can land in the same cycle: a control-register write and an access decode. The bench drives a write that disables the segment in the same cycle as a non-SMM read just below TOLM. It expects the blackhole answer, because the old setting still applies. It then repeats the read one cycle later and expects DRAM. The same overlap is exercised with the lock bit: a write that sets the lock and a new size together must take effect, while the write that follows must not.

// File: rtl/smd_pkg.sv
package smd_pkg;
  localparam int CTL_W    = 4;
  localparam int MB_SHIFT = 20;

  typedef enum logic [1:0] {
    RT_SYS    = 2'd0,
    RT_DRAM   = 2'd1,
    RT_HOLE   = 2'd2,
    RT_REJECT = 2'd3
  } route_e;

  typedef struct packed {
    logic       locked;
    logic [1:0] size_code;
    logic       seg_en;
  } ctl_t;
endpackage

// File: rtl/smd_ctrl_reg.sv
module smd_ctrl_reg
  import smd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output ctl_t             ctl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
    end else if (wr && !ctl.locked) begin
      ctl <= ctl_t'(wdata);
    end
  end
endmodule

// File: rtl/smd_seg_calc.sv
module smd_seg_calc
  import smd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TOLM_MB = 2048
) (
  input  ctl_t              ctl,
  output logic              seg_active,
  output logic [ADDR_W-1:0] seg_base,
  output logic              size_err
);
  localparam logic [ADDR_W-1:0] TOLM_BYTES = ADDR_W'(TOLM_MB) << MB_SHIFT;

  logic [3:0] raw_mb;
  logic [3:0] eff_mb;

  always_comb begin
    raw_mb = 4'd0;
    if (ctl.seg_en) begin
      unique case (ctl.size_code)
        2'b00:   raw_mb = 4'd1;
        2'b01:   raw_mb = 4'd2;
        2'b10:   raw_mb = 4'd8;
        default: raw_mb = 4'd0;
      endcase
    end
  end

  assign size_err   = {28'd0, raw_mb} > 32'(TOLM_MB);
  assign eff_mb     = size_err ? 4'd0 : raw_mb;
  assign seg_active = eff_mb != 4'd0;
  assign seg_base   = TOLM_BYTES - (ADDR_W'(eff_mb) << MB_SHIFT);
endmodule

// File: rtl/smd_route.sv
module smd_route
  import smd_pkg::*;
#(
  parameter int                ADDR_W  = 32,
  parameter int                DATA_W  = 32,
  parameter int                SIZE_W  = 3,
  parameter int                TOLM_MB = 2048,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFEDA_0000,
  parameter logic [ADDR_W-1:0] HI_SIZE = 32'h0002_0000,
  parameter logic [ADDR_W-1:0] HI_DRAM = 32'h000A_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic              write,
  input  logic              smm,
  input  logic              seg_active,
  input  logic [ADDR_W-1:0] seg_base,
  output route_e            route,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_out
);
  localparam int              LANES      = DATA_W / 8;
  localparam logic [ADDR_W-1:0] TOLM_BYTES = ADDR_W'(TOLM_MB) << MB_SHIFT;
  localparam logic [ADDR_W:0] HI_END     = {1'b0, HI_BASE} + {1'b0, HI_SIZE};

  logic size_ok, in_seg, in_hi, below_tolm, hole_rd;

  assign size_ok    = (size != '0) && (size <= SIZE_W'(LANES));
  assign below_tolm = addr < TOLM_BYTES;
  assign in_seg     = seg_active && (addr >= seg_base) && below_tolm;
  assign in_hi      = (addr >= HI_BASE) && ({1'b0, addr} < HI_END);

  always_comb begin
    route    = RT_SYS;
    out_addr = addr;
    wr_out   = write;
    if (!size_ok) begin
      route  = RT_REJECT;
      wr_out = 1'b0;
    end else if (in_seg) begin
      route  = smm ? RT_DRAM : RT_HOLE;
      wr_out = smm & write;
    end else if (in_hi) begin
      if (smm) begin
        route    = RT_DRAM;
        out_addr = addr - HI_BASE + HI_DRAM;
      end
    end else if (below_tolm) begin
      route = RT_DRAM;
    end
  end

  assign hole_rd = (route == RT_HOLE) && !write;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign rdata[8*b +: 8] = (hole_rd && (size > SIZE_W'(b))) ? 8'hFF : 8'h00;
  end
endmodule

// File: rtl/smram_seg_decoder.sv
module smram_seg_decoder
  import smd_pkg::*;
#(
  parameter int                ADDR_W  = 32,
  parameter int                DATA_W  = 32,
  parameter int                TOLM_MB = 2048,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFEDA_0000,
  parameter logic [ADDR_W-1:0] HI_SIZE = 32'h0002_0000,
  parameter logic [ADDR_W-1:0] HI_DRAM = 32'h000A_0000,
  localparam int               SIZE_W  = $clog2(DATA_W / 8 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [3:0]        ctl_wdata,
  output logic [3:0]        ctl_rdata,
  output logic              cfg_err,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              acc_write,
  input  logic              acc_smm,
  output logic              rsp_valid,
  output logic [1:0]        rsp_route,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_write
);
  ctl_t              ctl;
  logic              seg_active, size_err, nxt_wr;
  logic [ADDR_W-1:0] seg_base, nxt_addr;
  logic [DATA_W-1:0] nxt_rdata;
  route_e            nxt_route;

  smd_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .ctl   (ctl)
  );

  smd_seg_calc #(
    .ADDR_W  (ADDR_W),
    .TOLM_MB (TOLM_MB)
  ) u_calc (
    .ctl        (ctl),
    .seg_active (seg_active),
    .seg_base   (seg_base),
    .size_err   (size_err)
  );

  smd_route #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SIZE_W  (SIZE_W),
    .TOLM_MB (TOLM_MB),
    .HI_BASE (HI_BASE),
    .HI_SIZE (HI_SIZE),
    .HI_DRAM (HI_DRAM)
  ) u_route (
    .addr       (acc_addr),
    .size       (acc_size),
    .write      (acc_write),
    .smm        (acc_smm),
    .seg_active (seg_active),
    .seg_base   (seg_base),
    .route      (nxt_route),
    .out_addr   (nxt_addr),
    .rdata      (nxt_rdata),
    .wr_out     (nxt_wr)
  );

  assign ctl_rdata = ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_route <= RT_SYS;
      rsp_addr  <= '0;
      rsp_rdata <= '0;
      rsp_write <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_route <= nxt_route;
      rsp_addr  <= nxt_addr;
      rsp_rdata <= nxt_rdata;
      rsp_write <= nxt_wr;
      cfg_err   <= size_err;
    end
  end
endmodule

// File: rtl/smd_checker.sv
module smd_checker #(
  parameter int                ADDR_W  = 32,
  parameter int                SIZE_W  = 3,
  parameter int                LANES   = 4,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFEDA_0000,
  parameter logic [ADDR_W-1:0] HI_SIZE = 32'h0002_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        ctl_rdata,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [SIZE_W-1:0] acc_size,
  input logic              acc_smm,
  input logic              rsp_valid,
  input logic [1:0]        rsp_route,
  input logic              rsp_write
);
  localparam logic [ADDR_W:0] HI_END = {1'b0, HI_BASE} + {1'b0, HI_SIZE};

  p_hole_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_route == 2'd2) |-> !rsp_write);

  p_bad_size_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && ($past(acc_size) == '0 || $past(acc_size) > SIZE_W'(LANES)))
      |-> (rsp_route == 2'd3 && !rsp_write));

  p_hi_non_smm_sys_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(acc_smm) && $past(acc_size) != '0
     && $past(acc_size) <= SIZE_W'(LANES)
     && $past(acc_addr) >= HI_BASE && {1'b0, $past(acc_addr)} < HI_END)
      |-> rsp_route == 2'd0);

  p_lock_holds_r9: assert property (@(posedge clk) disable iff (rst)
    ctl_rdata[3] |=> $stable(ctl_rdata));

  p_rsp_follows_acc_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(acc_valid)) |-> rsp_valid);

  p_no_spurious_rsp_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(acc_valid));
endmodule

bind smram_seg_decoder smd_checker #(
  .ADDR_W  (ADDR_W),
  .SIZE_W  (SIZE_W),
  .LANES   (DATA_W / 8),
  .HI_BASE (HI_BASE),
  .HI_SIZE (HI_SIZE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_rdata (ctl_rdata),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .acc_size  (acc_size),
  .acc_smm   (acc_smm),
  .rsp_valid (rsp_valid),
  .rsp_route (rsp_route),
  .rsp_write (rsp_write)
);

// File: tb/smram_seg_decoder_tb_top.sv
`timescale 1ns/1ps
module smram_seg_decoder_tb_top;
  localparam int TOLM_A = 12;
  localparam int TOLM_B = 4;
  localparam logic [31:0] HI_B = 32'hFEDA_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1, ctl_wr = 1'b0, acc_valid = 1'b0, acc_write = 1'b0, acc_smm = 1'b0;
  logic [3:0]  ctl_wdata = '0;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_size = 3'd4;

  logic [3:0]  a_ctl, b_ctl;
  logic        a_err, b_err, a_v, b_v, a_w, b_w;
  logic [1:0]  a_r, b_r;
  logic [31:0] a_addr, b_addr, a_d, b_d;

  smram_seg_decoder #(.TOLM_MB(TOLM_A)) dut_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(a_ctl),
    .cfg_err(a_err), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_write(acc_write), .acc_smm(acc_smm), .rsp_valid(a_v), .rsp_route(a_r),
    .rsp_addr(a_addr), .rsp_rdata(a_d), .rsp_write(a_w));

  smram_seg_decoder #(.TOLM_MB(TOLM_B)) dut_small_i (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(b_ctl),
    .cfg_err(b_err), .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_write(acc_write), .acc_smm(acc_smm), .rsp_valid(b_v), .rsp_route(b_r),
    .rsp_addr(b_addr), .rsp_rdata(b_d), .rsp_write(b_w));

  int checks = 0, failures = 0, cyc = 0;
  logic [3:0] shadow = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int raw_mb(input logic [3:0] c);
    if (!c[0]) return 0;
    case (c[2:1])
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 8;
      default: return 0;
    endcase
  endfunction

  task automatic model(input int tolm_mb, input logic [3:0] c, input logic [31:0] a,
                       input int sz, input bit smm, input bit wr,
                       output logic [1:0] r, output logic [31:0] oa,
                       output logic [31:0] rd, output bit ow, output string tag);
    int mb = raw_mb(c);
    longint tolm = longint'(tolm_mb) << 20;
    longint base;
    if (mb > tolm_mb) mb = 0;
    base = tolm - (longint'(mb) << 20);
    oa = a; rd = '0; ow = wr;
    if (sz < 1 || sz > 4) begin
      r = 2'd3; ow = 1'b0; tag = "R7";
    end else if (mb != 0 && longint'(a) >= base && longint'(a) < tolm) begin
      if (smm) begin r = 2'd1; tag = "R3/R5"; end
      else begin
        r = 2'd2; ow = 1'b0; tag = "R3/R4";
        if (!wr) rd = (sz == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * sz)) - 32'd1);
      end
    end else if (a >= HI_B && a < HI_B + 32'h2_0000) begin
      tag = "R8";
      if (smm) begin r = 2'd1; oa = a - HI_B + 32'h000A_0000; end
      else r = 2'd0;
    end else if (longint'(a) < tolm) begin
      r = 2'd1; tag = c[0] ? "R6" : "R2";
    end else begin
      r = 2'd0; tag = "R6";
    end
  endtask

  task automatic check_one(input int tolm_mb, input logic [3:0] c, input logic [31:0] a,
                           input int sz, input bit smm, input bit wr,
                           input logic v, input logic [1:0] r, input logic [31:0] oa,
                           input logic [31:0] d, input logic w);
    logic [1:0] er; logic [31:0] ea, ed; bit ew; string tag;
    model(tolm_mb, c, a, sz, smm, wr, er, ea, ed, ew, tag);
    chk(v == 1'b1, "R12", "rsp_valid", longint'(v), 1);
    chk(r == er, tag, $sformatf("route a=%h sz=%0d smm=%0d wr=%0d", a, sz, smm, wr), r, er);
    chk(oa == ea, tag, $sformatf("addr a=%h", a), oa, ea);
    chk(d == ed && w == ew, tag, $sformatf("data/write a=%h", a), {d, 3'b0, w}, {ed, 3'b0, ew});
  endtask

  // Caller sits at a negedge; the access is sampled at the next posedge.
  task automatic access(input logic [31:0] a, input int sz, input bit smm, input bit wr);
    acc_valid = 1'b1; acc_addr = a; acc_size = 3'(sz); acc_smm = smm; acc_write = wr;
    @(negedge clk);
    check_one(TOLM_A, shadow, a, sz, smm, wr, a_v, a_r, a_addr, a_d, a_w);
    check_one(TOLM_B, shadow, a, sz, smm, wr, b_v, b_r, b_addr, b_d, b_w);
  endtask

  task automatic ctl_write(input logic [3:0] w);
    acc_valid = 1'b0;
    ctl_wr = 1'b1; ctl_wdata = w;
    @(negedge clk);
    ctl_wr = 1'b0;
    if (!shadow[3]) shadow = w;
    chk(a_ctl == shadow && b_ctl == shadow, "R9", "ctl_rdata", {a_ctl, b_ctl}, {shadow, shadow});
    @(negedge clk);
    chk(a_err == (raw_mb(shadow) > TOLM_A), "R11", "cfg_err big", a_err, raw_mb(shadow) > TOLM_A);
    chk(b_err == (raw_mb(shadow) > TOLM_B), "R11", "cfg_err small", b_err, raw_mb(shadow) > TOLM_B);
  endtask

  task automatic do_reset();
    acc_valid = 1'b0; ctl_wr = 1'b0; rst = 1'b1;
    repeat (3) @(negedge clk);
    shadow = '0;
    chk(!a_v && !b_v, "R1", "rsp_valid in reset", {a_v, b_v}, 0);
    chk(a_ctl == 4'd0 && b_ctl == 4'd0, "R1", "ctl_rdata in reset", {a_ctl, b_ctl}, 0);
    chk(!a_err && !b_err, "R1", "cfg_err in reset", {a_err, b_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!a_v && a_ctl == 4'd0, "R1", "state after reset", {a_v, a_ctl}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == 190000) begin
        failures++;
        $display("FAIL R12 watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    do_reset();

    // R2/R3/R4/R5/R6/R11: sweep every control setting over 0..16 MB
    for (int cfg = 0; cfg < 8; cfg++) begin
      ctl_write(4'(cfg));
      for (int k = 0; k < 128; k++) begin
        for (int v = 0; v < 2; v++) begin
          for (int m = 0; m < 4; m++) begin
            access(32'(k) * 32'h2_0000 + (v != 0 ? 32'h1_FFFF : 32'h0),
                   1 + ((k + m) % 4), m[0], m[1]);
          end
        end
      end
    end

    // R8: high window edges, both modes
    ctl_write(4'h1);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] ha;
      case (i)
        0: ha = 32'hFED9_FFFF; 1: ha = 32'hFEDA_0000; 2: ha = 32'hFEDA_1234;
        3: ha = 32'hFEDB_FFFF; 4: ha = 32'hFEDC_0000; default: ha = 32'hFFFF_FFFC;
      endcase
      for (int m = 0; m < 4; m++) access(ha, 4, m[0], m[1]);
    end

    // R7: rejected sizes, inside and outside the segment
    for (int s = 0; s < 8; s++) begin
      if (s >= 1 && s <= 4) continue;
      access(32'h00BF_FFF0, s, 1'b0, 1'b0);
      access(32'h0000_1000, s, 1'b1, 1'b1);
    end

    // R10: control write and access in the same cycle use the old setting
    ctl_write(4'h1);
    acc_valid = 1'b1; acc_addr = 32'h00BF_FFFC; acc_size = 3'd4; acc_smm = 1'b0; acc_write = 1'b0;
    ctl_wr = 1'b1; ctl_wdata = 4'h0;
    @(negedge clk);
    ctl_wr = 1'b0;
    chk(a_r == 2'd2 && a_d == 32'hFFFF_FFFF, "R10", "same-cycle uses old", {a_r, a_d}, {2'd2, 32'hFFFF_FFFF});
    shadow = 4'h0;
    @(negedge clk);
    chk(a_r == 2'd1 && a_d == 32'h0, "R10", "next cycle uses new", {a_r, a_d}, {2'd1, 32'h0});
    acc_valid = 1'b0;
    @(negedge clk);
    chk(!a_v && !b_v, "R12", "idle gives no response", {a_v, b_v}, 0);

    // R9: lock with a new size in one write, then a write that must be ignored
    ctl_write(4'hB);
    ctl_write(4'h0);
    access(32'h00A0_0000, 2, 1'b0, 1'b0);
    access(32'h00A0_0000, 4, 1'b0, 1'b1);
    access(32'h009F_FFFF, 1, 1'b0, 1'b0);

    do_reset();
    access(32'h00BF_FFFC, 4, 1'b0, 1'b0);

    acc_valid = 1'b0;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule